// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide ports, called A and B, and moves data from one to the other. It can also isolate them from each other. Each port has its own holding register. The register for A takes the A-side value on the rising edge of its own clock, and the register for B takes the B-side value on the rising edge of a second clock. Both registers capture whatever the rest of the controls are doing, so a value can be stored while the ports are isolated or while the opposite port is driving.

An active-low enable either lets one port drive or keeps both ports quiet. When the enable is active, a direction input picks which port drives. For each direction, a select input picks what the driven port shows:
- the live value arriving at the opposite port, through a purely combinational path;
- the value held in the opposite port's register.

Each port is modelled as three vectors: an input vector, an output vector and an output-enable vector. This keeps the block synthesizable and free of tri-state nets. A chip-level pad ring or a bus fabric merges the three vectors into a real bidirectional pin.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `rst_n` is low, both output-enable vectors are all zeros. A rising edge of `clk_ab` or `clk_ba` that sees `rst_n` low clears the register of that clock to 0x00.
- R2: With `rst_n` high, the A register loads `a_in` on every rising edge of `clk_ab`, whatever the values of `oe_n`, `dir` and the selects.
- R3: With `rst_n` high, the B register loads `b_in` on every rising edge of `clk_ba`, whatever the values of `oe_n`, `dir` and the selects.
- R4: While `oe_n` is 1 (isolation), `a_oe` and `b_oe` are all zeros, and both registers can still be loaded.
- R5: With `oe_n` at 0, `dir` at 1 gives `b_oe` all ones and `a_oe` all zeros. `dir` at 0 gives the opposite. Each enable vector is always either all ones or all zeros, and the two vectors are never non-zero at the same time.
- R6: With `oe_n` 0, `dir` 1 and `sel_ab` 0, `b_out` equals `a_in` in the same cycle, with no register stage.
- R7: With `oe_n` 0, `dir` 1 and `sel_ab` 1, `b_out` equals the A register.
- R8: With `oe_n` 0 and `dir` 0, `a_out` equals `b_in` when `sel_ba` is 0, and equals the B register when `sel_ba` is 1.
- R9: While port B drives, `sel_ba`, `b_in` and edges on `clk_ba` leave `a_out`, `a_oe`, `b_out` and `b_oe` unchanged. While port A drives, `sel_ab`, `a_in` and edges on `clk_ab` leave them unchanged in the same way, except that `a_in` and `clk_ab` still load the A register.
- R10: In a stored mode, an edge on the driving register's clock loads that register, and the new value appears on the driven port straight after that edge.
- R11: An output vector whose port is not driving is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Load clock of the A register (rising edge) |
| clk_ba | input | 1 | Load clock of the B register (rising edge) |
| rst_n | input | 1 | Active-low reset, synchronous to each register's own clock |
| oe_n | input | 1 | Active-low enable; 1 isolates both ports |
| dir | input | 1 | 1: port B driven from the A side; 0: port A driven from the B side |
| sel_ab | input | 1 | Source for port B: 0 live `a_in`, 1 A register |
| sel_ba | input | 1 | Source for port A: 0 live `b_in`, 1 B register |
| a_in | input | DATA_W | Value arriving at port A |
| a_out | output | DATA_W | Value port A drives |
| a_oe | output | DATA_W | Per-bit drive enable of port A |
| b_in | input | DATA_W | Value arriving at port B |
| b_out | output | DATA_W | Value port B drives |
| b_oe | output | DATA_W | Per-bit drive enable of port B |

## Verification
The bench builds the block with the default `DATA_W` of 8. It uses complementary and walking byte patterns, such as 0x5A and 0xA5, and 0x01 and 0x80, so that a swapped bit, a wrong source or a stuck lane gives a different value on the driven port. Because the two load clocks are pulsed separately and also together, the bench can load one register while the other port drives. It can also load a register in isolation and read the value back later through a stored mode.

// File: rtl/trx_pkg.sv
`timescale 1ns/1ps
package trx_pkg;

  typedef enum logic [2:0] {
    XM_HOLD      = 3'd0,
    XM_ISOLATE   = 3'd1,
    XM_AB_LIVE   = 3'd2,
    XM_AB_STORED = 3'd3,
    XM_BA_LIVE   = 3'd4,
    XM_BA_STORED = 3'd5
  } xfer_mode_e;

  // Reset has priority, then the enable, then the direction, then the select.
  function automatic xfer_mode_e decode_mode(
    input logic rst_n,
    input logic oe_n,
    input logic dir,
    input logic sel_ab,
    input logic sel_ba
  );
    xfer_mode_e m;
    if (!rst_n)    m = XM_HOLD;
    else if (oe_n) m = XM_ISOLATE;
    else if (dir)  m = sel_ab ? XM_AB_STORED : XM_AB_LIVE;
    else           m = sel_ba ? XM_BA_STORED : XM_BA_LIVE;
    return m;
  endfunction

  function automatic logic mode_drives_b(input xfer_mode_e m);
    return (m == XM_AB_LIVE) || (m == XM_AB_STORED);
  endfunction

  function automatic logic mode_drives_a(input xfer_mode_e m);
    return (m == XM_BA_LIVE) || (m == XM_BA_STORED);
  endfunction

  function automatic logic mode_is_stored(input xfer_mode_e m);
    return (m == XM_AB_STORED) || (m == XM_BA_STORED);
  endfunction

endpackage

// File: rtl/trx_capture_reg.sv
`timescale 1ns/1ps
module trx_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1: an edge that sees reset leaves the register cleared
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> q == '0);

  // R2 / R3: every edge outside reset loads the port value
  a_r2_r3_loads_input: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

endmodule

// File: rtl/trx_mode_decode.sv
`timescale 1ns/1ps
module trx_mode_decode
  import trx_pkg::*;
(
  input  logic       rst_n,
  input  logic       oe_n,
  input  logic       dir,
  input  logic       sel_ab,
  input  logic       sel_ba,
  output xfer_mode_e mode,
  output logic       drive_a,
  output logic       drive_b,
  output logic       stored
);

  always_comb begin
    mode    = decode_mode(rst_n, oe_n, dir, sel_ab, sel_ba);
    drive_a = mode_drives_a(mode);
    drive_b = mode_drives_b(mode);
    stored  = mode_is_stored(mode);
  end

  // R5: at most one port is granted the drive
  always_comb begin
    a_r5_single_grant: assert ($onehot0({drive_a, drive_b}));
  end

endmodule

// File: rtl/trx_port_driver.sv
`timescale 1ns/1ps
module trx_port_driver #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_reg,
  input  logic [W-1:0] live_val,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] port_out,
  output logic [W-1:0] port_oe
);

  logic [W-1:0] src;

  always_comb begin
    src = use_reg ? reg_val : live_val;
  end

  // Each lane is gated by the same grant.
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign port_out[i] = drive & src[i];
    assign port_oe[i]  = drive;
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
module bus_xcvr_reg
  import trx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_ab,
  input  logic              clk_ba,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              dir,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic [DATA_W-1:0] b_oe
);

  localparam logic [DATA_W-1:0] ALL_ON = {DATA_W{1'b1}};

  // Named internal events, brought out for the checks.
  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;
  xfer_mode_e        mode;
  logic              grant_a;
  logic              grant_b;
  logic              from_reg;

  trx_capture_reg #(.W(DATA_W)) i_reg_a (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(held_a)
  );

  trx_capture_reg #(.W(DATA_W)) i_reg_b (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(held_b)
  );

  trx_mode_decode i_decode (
    .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .mode(mode), .drive_a(grant_a), .drive_b(grant_b), .stored(from_reg)
  );

  trx_port_driver #(.W(DATA_W)) i_drv_b (
    .drive(grant_b), .use_reg(from_reg), .live_val(a_in), .reg_val(held_a),
    .port_out(b_out), .port_oe(b_oe)
  );

  trx_port_driver #(.W(DATA_W)) i_drv_a (
    .drive(grant_a), .use_reg(from_reg), .live_val(b_in), .reg_val(held_b),
    .port_out(a_out), .port_oe(a_oe)
  );

  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (a_oe == '0 && b_oe == '0);
    end
    if (rst_n && oe_n) begin
      a_r4_isolation: assert (a_oe == '0 && b_oe == '0);
    end
    a_r5_uniform_a: assert (a_oe == '0 || a_oe == ALL_ON);
    a_r5_uniform_b: assert (b_oe == '0 || b_oe == ALL_ON);
    a_r5_never_both: assert (!((|a_oe) && (|b_oe)));
    if (mode == XM_AB_LIVE) begin
      a_r6_ab_transparent: assert (b_out == a_in && b_oe == ALL_ON);
    end
    if (mode == XM_AB_STORED) begin
      a_r7_ab_stored: assert (b_out == held_a);
    end
    if (mode == XM_BA_LIVE) begin
      a_r8_ba_transparent: assert (a_out == b_in && a_oe == ALL_ON);
    end
    if (mode == XM_BA_STORED) begin
      a_r8_ba_stored: assert (a_out == held_b);
    end
    if (a_oe == '0) begin
      a_r11_idle_a_zero: assert (a_out == '0);
    end
    if (b_oe == '0) begin
      a_r11_idle_b_zero: assert (b_out == '0);
    end
  end

endmodule

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;

  localparam int W = 8;

  logic         clk_ab = 1'b0;
  logic         clk_ba = 1'b0;
  logic         rst_n  = 1'b0;
  logic         oe_n   = 1'b1;
  logic         dir    = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic [W-1:0] a_in   = '0;
  logic [W-1:0] b_in   = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state: the two held bytes.
  int ref_a = 0;
  int ref_b = 0;

  bus_xcvr_reg #(.DATA_W(W)) i_bus_xcvr_reg (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // One 8 ns (125 MHz) period on the selected load clocks.
  task automatic tick(input bit pulse_ab, input bit pulse_ba);
    #4;
    if (pulse_ab) ref_a = rst_n ? int'(a_in) : 0;
    if (pulse_ba) ref_b = rst_n ? int'(b_in) : 0;
    clk_ab = pulse_ab;
    clk_ba = pulse_ba;
    #4;
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #1;
  endtask

  task automatic check(input string req);
    int ea_out, ea_oe, eb_out, eb_oe;
    ea_out = 0; ea_oe = 0; eb_out = 0; eb_oe = 0;
    if (rst_n && !oe_n) begin
      if (dir) begin
        eb_oe  = 255;
        eb_out = sel_ab ? ref_a : int'(a_in);
      end else begin
        ea_oe  = 255;
        ea_out = sel_ba ? ref_b : int'(b_in);
      end
    end
    checks++;
    if (int'(a_out) != ea_out || int'(a_oe) != ea_oe ||
        int'(b_out) != eb_out || int'(b_oe) != eb_oe) begin
      errors++;
      $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h expected %h %h %h %h",
               req, a_out, a_oe, b_out, b_oe,
               ea_out[7:0], ea_oe[7:0], eb_out[7:0], eb_oe[7:0]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [6] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80};

    // R1: reset clears both registers and holds the enables low
    a_in = 8'h5A; b_in = 8'hA5; oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1; check("R1");
    tick(1, 1); check("R1");
    rst_n = 1'b1; #1; check("R1");
    dir = 1'b0; sel_ba = 1'b1; #1; check("R1");

    // R4: isolation; registers still load (R2, R3)
    oe_n = 1'b1;
    a_in = 8'h3C; tick(1, 0); check("R4");
    b_in = 8'hC3; tick(0, 1); check("R4");
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'h00; #1; check("R2");
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h00; #1; check("R3");

    // R5 / R6: live A to B, combinational same cycle
    dir = 1'b1; sel_ab = 1'b0;
    foreach (pats[i]) begin
      a_in = pats[i]; #1; check("R6");
    end

    // R9: B-side controls ignored while B drives
    sel_ab = 1'b1; #1; check("R7");
    sel_ba = 1'b0; b_in = 8'h66; tick(0, 1); check("R9");
    sel_ba = 1'b1; b_in = 8'h99; #1; check("R9");
    dir = 1'b0; #1; check("R3");

    // R10: load and show in the same cycle in stored mode
    dir = 1'b1; sel_ab = 1'b1;
    a_in = 8'h81; tick(1, 0); check("R10");
    a_in = 8'h7E; #1; check("R7");
    tick(1, 0); check("R10");

    // R8: B to A, live then stored; R9 mirror
    dir = 1'b0; sel_ba = 1'b0;
    foreach (pats[i]) begin
      b_in = pats[i]; #1; check("R8");
    end
    sel_ba = 1'b1; #1; check("R8");
    sel_ab = 1'b0; a_in = 8'h12; tick(1, 0); check("R9");
    b_in = 8'h24; tick(0, 1); check("R10");

    // R2 / R3: both clocks together, each register independent
    a_in = 8'hF0; b_in = 8'h0F; tick(1, 1); check("R3");
    dir = 1'b1; sel_ab = 1'b1; #1; check("R2");

    // R11: idle port output is zero in every mode
    oe_n = 1'b1; #1; check("R11");
    oe_n = 1'b0; #1; check("R11");

    // R1: reset mid-run clears and silences
    dir = 1'b0; sel_ba = 1'b1;
    rst_n = 1'b0; #1; check("R1");
    tick(1, 1); check("R1");
    rst_n = 1'b1; #1; check("R1");
    dir = 1'b1; #1; check("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule